// File: doc/BRIEF.md
# Debug Run and Halt Controller

This block decides, cycle by cycle, whether a small processor core executes, sits stopped, or advances by a single instruction under the control of a debug host. The host issues pulse commands to stop, continue and advance one instruction. It polls a halted flag to find out when the core has stopped on its own. The core feeds the controller a strobe when it decodes a break opcode, a strobe for each retired instruction, and a strobe from a breakpoint comparator.

While the core is stopped, the controller gates peripheral activity selectively. The watchdog is frozen so that a debug pause cannot cause a device reset. Timers either keep counting at full rate or advance only while a stepped instruction executes; a configuration input picks which. All other peripherals keep running.

When the core stops on a break opcode, the opcode never takes effect. On the next start, the core is told to execute a host-supplied replacement instruction once before it fetches from program memory again.

Top module: `dbg_runctl`

## Requirements
- R1: After reset the controller is running, with `halted_o`=0, `core_stall_o`=0, `subst_sel_o`=0, `wdt_en_o`=1, and every bit of `tmr_en_o` and `periph_en_o` at 1.
- R2: A `host_halt_i` pulse while not halted sets `halted_o` and `core_stall_o` from the next cycle on.
- R3: A `brk_op_i` strobe while running or stepping raises `core_stall_o` in the same cycle, so the opcode does not execute. `halted_o` rises on the next cycle.
- R4: A `bp_hit_i` strobe while not halted halts the core in the cycle after the next `retire_i`, including a retire in the same cycle as the hit. A hit seen while halted is discarded.
- R5: A `host_resume_i` pulse while halted clears `halted_o` and `core_stall_o` on the next cycle, and the core runs freely.
- R6: A `host_step_i` pulse while halted clears `halted_o` and `core_stall_o` on the next cycle. After exactly one `retire_i`, `halted_o` is set again on the following cycle.
- R7: While halted, a halt request together with a step command keeps the core halted. A step command together with a resume command starts a single step rather than free running.
- R8: After a break-opcode halt, the next resume or step raises `subst_sel_o` until the first `retire_i`, and it is low on the cycle after that retire. A `brk_op_i` strobe while `subst_sel_o` is high is ignored and does not stall the core.
- R9: `wdt_en_o` is 1 only while running freely. It is 0 while halted and while a single step is in progress.
- R10: With `cfg_tmr_run_i`=1, all `tmr_en_o` bits stay 1 in every state. With `cfg_tmr_run_i`=0, they are 0 while halted and 1 while running or stepping.
- R11: Every `periph_en_o` bit stays 1 in every state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_halt_i | input | 1 | Host stop request pulse |
| host_resume_i | input | 1 | Host start (free run) pulse |
| host_step_i | input | 1 | Host single-instruction pulse |
| brk_op_i | input | 1 | Break opcode decoded by the core |
| bp_hit_i | input | 1 | Breakpoint comparator match strobe |
| retire_i | input | 1 | One instruction retired this cycle |
| cfg_tmr_run_i | input | 1 | 1: timers free-run while stopped; 0: timers follow stepped cycles |
| core_stall_o | output | 1 | Holds the core pipeline |
| halted_o | output | 1 | Core is in the halted state |
| subst_sel_o | output | 1 | Core must execute the host-supplied replacement instruction |
| wdt_en_o | output | 1 | Watchdog enable |
| tmr_en_o | output | N_TMR | Timer enables |
| periph_en_o | output | N_PERIP | Enables of all other peripherals |

## Verification
The checker confirms the following on every cycle: a halted core is always stalled, the watchdog is frozen whenever the core is halted, and the timer enables follow the configuration bit. It also confirms that a break strobe stalls the core at once, that a halt request is honoured on the next edge, and that a retire during a step returns the core to halt.

Some behaviours depend on the history of commands, so only the bench scenarios can show them. These are the breakpoint boundary wait across idle cycles, the discarded hit while halted, the step-over-resume priority, and the replacement-instruction window lasting exactly until the first retire. The bench runs every scenario under both timer settings.

// File: rtl/dbg_runctl_pkg.sv
package dbg_runctl_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_HALT = 2'd1,
    ST_STEP = 2'd2
  } run_st_e;
endpackage

// File: rtl/dbg_cmd_arb.sv
module dbg_cmd_arb
  import dbg_runctl_pkg::*;
(
  input  run_st_e st,
  input  logic    host_halt,
  input  logic    host_resume,
  input  logic    host_step,
  input  logic    brk_eff,
  input  logic    bp_boundary,
  input  logic    retire,
  output run_st_e st_nxt
);
  // Priority while halted: halt > step > resume.
  always_comb begin
    st_nxt = st;
    unique case (st)
      ST_RUN: begin
        if (host_halt || brk_eff || bp_boundary) st_nxt = ST_HALT;
      end
      ST_STEP: begin
        if (host_halt || brk_eff || retire || bp_boundary) st_nxt = ST_HALT;
      end
      ST_HALT: begin
        if (host_halt)        st_nxt = ST_HALT;
        else if (host_step)   st_nxt = ST_STEP;
        else if (host_resume) st_nxt = ST_RUN;
      end
      default: st_nxt = ST_HALT;
    endcase
  end
endmodule

// File: rtl/dbg_run_fsm.sv
module dbg_run_fsm
  import dbg_runctl_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    host_halt,
  input  logic    host_resume,
  input  logic    host_step,
  input  logic    brk_op,
  input  logic    bp_hit,
  input  logic    retire,
  output run_st_e st,
  output logic    subst_sel,
  output logic    stall
);
  run_st_e st_q, st_d;
  logic    subst_q, subst_d;
  logic    bp_pend_q, bp_pend_d;
  logic    live, brk_eff, bp_boundary, to_halt;

  assign live        = (st_q != ST_HALT);
  assign subst_sel   = subst_q && live;
  assign brk_eff     = brk_op && live && !subst_sel;
  assign bp_boundary = live && retire && (bp_hit || bp_pend_q);

  dbg_cmd_arb u_arb (
    .st          (st_q),
    .host_halt   (host_halt),
    .host_resume (host_resume),
    .host_step   (host_step),
    .brk_eff     (brk_eff),
    .bp_boundary (bp_boundary),
    .retire      (retire),
    .st_nxt      (st_d)
  );

  assign to_halt = live && (st_d == ST_HALT);

  always_comb begin
    subst_d = subst_q;
    if (brk_eff)                 subst_d = 1'b1;
    else if (subst_sel && retire) subst_d = 1'b0;
  end

  always_comb begin
    bp_pend_d = bp_pend_q;
    if (to_halt || !live)        bp_pend_d = 1'b0;
    else if (bp_hit)             bp_pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_RUN;
      subst_q   <= 1'b0;
      bp_pend_q <= 1'b0;
    end else begin
      st_q      <= st_d;
      subst_q   <= subst_d;
      bp_pend_q <= bp_pend_d;
    end
  end

  assign st    = st_q;
  assign stall = (st_q == ST_HALT) || brk_eff;
endmodule

// File: rtl/dbg_clk_gate.sv
module dbg_clk_gate
  import dbg_runctl_pkg::*;
#(
  parameter int N_TMR   = 2,
  parameter int N_PERIP = 4
) (
  input  run_st_e            st,
  input  logic               cfg_tmr_run,
  output logic               wdt_en,
  output logic [N_TMR-1:0]   tmr_en,
  output logic [N_PERIP-1:0] periph_en
);
  logic tmr_go;

  assign wdt_en = (st == ST_RUN);
  assign tmr_go = cfg_tmr_run || (st != ST_HALT);

  for (genvar t = 0; t < N_TMR; t++) begin : g_tmr
    assign tmr_en[t] = tmr_go;
  end

  assign periph_en = '1;
endmodule

// File: rtl/dbg_runctl.sv
module dbg_runctl
  import dbg_runctl_pkg::*;
#(
  parameter int N_TMR   = 2,
  parameter int N_PERIP = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_halt_i,
  input  logic               host_resume_i,
  input  logic               host_step_i,
  input  logic               brk_op_i,
  input  logic               bp_hit_i,
  input  logic               retire_i,
  input  logic               cfg_tmr_run_i,
  output logic               core_stall_o,
  output logic               halted_o,
  output logic               subst_sel_o,
  output logic               wdt_en_o,
  output logic [N_TMR-1:0]   tmr_en_o,
  output logic [N_PERIP-1:0] periph_en_o
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  run_st_e    st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  dbg_run_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .host_halt   (host_halt_i),
    .host_resume (host_resume_i),
    .host_step   (host_step_i),
    .brk_op      (brk_op_i),
    .bp_hit      (bp_hit_i),
    .retire      (retire_i),
    .st          (st),
    .subst_sel   (subst_sel_o),
    .stall       (core_stall_o)
  );

  dbg_clk_gate #(.N_TMR(N_TMR), .N_PERIP(N_PERIP)) u_gate (
    .st          (st),
    .cfg_tmr_run (cfg_tmr_run_i),
    .wdt_en      (wdt_en_o),
    .tmr_en      (tmr_en_o),
    .periph_en   (periph_en_o)
  );

  assign halted_o = (st == ST_HALT);
endmodule

// File: rtl/dbg_runctl_chk.sv
module dbg_runctl_chk #(
  parameter int N_TMR   = 2,
  parameter int N_PERIP = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               host_halt_i,
  input logic               brk_op_i,
  input logic               retire_i,
  input logic               host_step_i,
  input logic               cfg_tmr_run_i,
  input logic               core_stall_o,
  input logic               halted_o,
  input logic               subst_sel_o,
  input logic               wdt_en_o,
  input logic [N_TMR-1:0]   tmr_en_o
);
  assert_halt_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!halted_o && host_halt_i) |=> halted_o);
  assert_halted_stalls_R2: assert property (@(posedge clk) disable iff (!rst_n)
    halted_o |-> core_stall_o);
  assert_brk_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_op_i && !halted_o && !subst_sel_o) |-> core_stall_o);
  assert_step_retire_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!halted_o && !wdt_en_o && retire_i) |=> halted_o);
  assert_halt_beats_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (halted_o && host_halt_i && host_step_i) |=> halted_o);
  assert_subst_live_R8: assert property (@(posedge clk) disable iff (!rst_n)
    subst_sel_o |-> !halted_o);
  assert_subst_no_brk_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (subst_sel_o && brk_op_i) |-> !core_stall_o);
  assert_wdt_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    halted_o |-> !wdt_en_o);
  assert_tmr_free_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_tmr_run_i |-> (tmr_en_o == {N_TMR{1'b1}}));
  assert_tmr_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (halted_o && !cfg_tmr_run_i) |-> (tmr_en_o == '0));
endmodule

bind dbg_runctl dbg_runctl_chk #(.N_TMR(N_TMR), .N_PERIP(N_PERIP)) u_chk (
  .clk           (clk),
  .rst_n         (rst_int_n),
  .host_halt_i   (host_halt_i),
  .brk_op_i      (brk_op_i),
  .retire_i      (retire_i),
  .host_step_i   (host_step_i),
  .cfg_tmr_run_i (cfg_tmr_run_i),
  .core_stall_o  (core_stall_o),
  .halted_o      (halted_o),
  .subst_sel_o   (subst_sel_o),
  .wdt_en_o      (wdt_en_o),
  .tmr_en_o      (tmr_en_o)
);

// File: tb/tb_dbg_runctl.sv
`timescale 1ns/1ps
module tb_dbg_runctl;
  localparam int NT = 2;
  localparam int NP = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic h, r, s, b, p, rt, cfg;
  logic stall, halted, subst, wdt;
  logic [NT-1:0] tmr;
  logic [NP-1:0] per;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  dbg_runctl #(.N_TMR(NT), .N_PERIP(NP)) dut (
    .clk(clk), .rst_n(rst_n), .host_halt_i(h), .host_resume_i(r),
    .host_step_i(s), .brk_op_i(b), .bp_hit_i(p), .retire_i(rt),
    .cfg_tmr_run_i(cfg), .core_stall_o(stall), .halted_o(halted),
    .subst_sel_o(subst), .wdt_en_o(wdt), .tmr_en_o(tmr), .periph_en_o(per)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(logic ih, logic ir, logic is, logic ib, logic ip, logic irt);
    @(negedge clk);
    h = ih; r = ir; s = is; b = ib; p = ip; rt = irt;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    h = 0; r = 0; s = 0; b = 0; p = 0; rt = 0;
  endtask

  task automatic chk_en(bit is_halted, bit stepping);
    logic [31:0] exp_t;
    exp_t = (cfg || !is_halted) ? 32'(2**NT - 1) : 32'd0;
    chk("R9 watchdog enable", 32'(wdt), 32'(!(is_halted || stepping)));
    chk("R10 timer enables", 32'(tmr), exp_t);
    chk("R11 peripheral enables", 32'(per), 32'(2**NP - 1));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    h = 0; r = 0; s = 0; b = 0; p = 0; rt = 0; cfg = 0; rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    repeat (4) @(posedge clk);
    #1;
    chk("R1 halted", 32'(halted), 0);
    chk("R1 stall", 32'(stall), 0);
    chk("R1 subst", 32'(subst), 0);
    chk_en(0, 0);

    for (int c = 0; c < 2; c++) begin
      @(negedge clk) cfg = c[0];
      #1 chk_en(0, 0);
      // R2 host halt
      drive(1,0,0,0,0,0); tick();
      chk("R2 halted", 32'(halted), 1);
      chk("R2 stall", 32'(stall), 1);
      chk_en(1, 0);
      // R6 single step
      drive(0,0,1,0,0,0); tick();
      chk("R6 halted during step", 32'(halted), 0);
      chk("R6 stall during step", 32'(stall), 0);
      chk_en(0, 1);
      drive(0,0,0,0,0,0); tick();
      chk("R6 waits for retire", 32'(halted), 0);
      drive(0,0,0,0,0,1); tick();
      chk("R6 halted after retire", 32'(halted), 1);
      chk("R6 stall after retire", 32'(stall), 1);
      // R7 priorities
      drive(1,0,1,0,0,0); tick();
      chk("R7 halt beats step", 32'(halted), 1);
      drive(0,1,1,0,0,0); tick();
      chk("R7 step beats resume", 32'(halted), 0);
      chk_en(0, 1);
      drive(0,0,0,0,0,1); tick();
      chk("R7 step ends on retire", 32'(halted), 1);
      // R5 resume
      drive(0,1,0,0,0,0); tick();
      chk("R5 halted", 32'(halted), 0);
      chk("R5 stall", 32'(stall), 0);
      chk_en(0, 0);
      // R3 break opcode
      drive(0,0,0,1,0,0);
      #1 chk("R3 stall same cycle", 32'(stall), 1);
      chk("R3 not yet halted", 32'(halted), 0);
      tick();
      chk("R3 halted", 32'(halted), 1);
      // R8 replacement instruction on resume
      drive(0,1,0,0,0,0); tick();
      chk("R8 subst after resume", 32'(subst), 1);
      chk("R8 running", 32'(halted), 0);
      drive(0,0,0,1,0,0);
      #1 chk("R8 brk ignored no stall", 32'(stall), 0);
      tick();
      chk("R8 brk ignored no halt", 32'(halted), 0);
      chk("R8 subst held", 32'(subst), 1);
      drive(0,0,0,0,0,1); tick();
      chk("R8 subst cleared", 32'(subst), 0);
      chk("R8 still running", 32'(halted), 0);
      // R4 breakpoint waits for boundary
      drive(0,0,0,0,1,0); tick();
      chk("R4 no halt before retire", 32'(halted), 0);
      drive(0,0,0,0,0,0); tick();
      chk("R4 still waiting", 32'(halted), 0);
      drive(0,0,0,0,0,1); tick();
      chk("R4 halt at boundary", 32'(halted), 1);
      drive(0,1,0,0,0,0); tick();
      drive(0,0,0,0,1,1); tick();
      chk("R4 coincident hit and retire", 32'(halted), 1);
      drive(0,0,0,0,1,0); tick();
      drive(0,1,0,0,0,0); tick();
      drive(0,0,0,0,0,1); tick();
      chk("R4 hit while halted discarded", 32'(halted), 0);
      // R8 break then step
      drive(0,0,0,1,0,0); tick();
      chk("R3 halted again", 32'(halted), 1);
      drive(0,0,1,0,0,0); tick();
      chk("R8 subst during step", 32'(subst), 1);
      drive(0,0,0,0,0,1); tick();
      chk("R8 step halts after subst", 32'(halted), 1);
      chk("R8 subst cleared on step", 32'(subst), 0);
      drive(0,1,0,0,0,0); tick();
      chk("R5 resume again", 32'(halted), 0);
      chk("R8 no subst repeat", 32'(subst), 0);
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule